// File: doc/BRIEF.md
# Hysteretic Signal Presence Detector

This block watches a stream of signal-level magnitudes, one per clock, such as the output of a rectify-and-average stage that follows a bandpass filter. It decides whether a signal is present and reports the decision as a qualified presence flag. The decision uses hysteresis in amplitude and in time. The flag is raised only after the level has stayed above an on-threshold without a break for a programmable number of cycles. It is dropped only after the level has stayed below a lower off-threshold without a break for a second programmable number of cycles.

A mode input picks one of two threshold pairs. In carrier-receive mode the qualified result drives the presence output `det`. In tone-alert mode the thresholds for the dual-tone path are used instead, and the qualified result goes to `tone_lvl_ok`, which feeds a downstream tone detector; `det` stays low in that mode. A change of mode clears the flag and both persistence timers, so qualification always starts fresh under the new thresholds. A cycle count of zero selects the default count given by a parameter; the defaults correspond to about 20 ms on and 8 ms off at the system clock.

Top module: `sig_presence_det`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `det` and `tone_lvl_ok` are 0.
- R2: In carrier mode (`mode`=0), `det` becomes 1 after `on_cycles` consecutive clock edges at which `level` is strictly greater than `car_on_thr`, and not earlier. A level equal to the threshold does not count as above it.
- R3: A single edge with `level` not above the active on-threshold, before the on-count completes, restarts the on-count from zero.
- R4: While the flag is set, it clears after `off_cycles` consecutive edges at which `level` is strictly below the active off-threshold, and not earlier.
- R5: While the flag is set, a single edge with `level` at or above the active off-threshold restarts the off-count from zero.
- R6: A level between the off-threshold and the on-threshold, inclusive, leaves the flag unchanged indefinitely, whether it is set or clear.
- R7: In tone mode (`mode`=1), `tone_lvl_ok` follows the same qualification against `tone_on_thr`/`tone_off_thr`, and `det` is held at 0.
- R8: At the edge where `mode` differs from its value at the previous edge, the flag and both timers are cleared, regardless of any timer that would have expired at that edge; counting restarts at the next edge.
- R9: A value of 0 on `on_cycles` or `off_cycles` selects the parameter `DEF_ON_CYC` or `DEF_OFF_CYC`, respectively.
- R10: `det` and `tone_lvl_ok` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 selects carrier receive, 1 selects tone alert |
| level | input | LW | Signal-level magnitude sample, one per clock |
| car_on_thr | input | LW | Carrier on-threshold |
| car_off_thr | input | LW | Carrier off-threshold (set below the on-threshold) |
| tone_on_thr | input | LW | Tone on-threshold |
| tone_off_thr | input | LW | Tone off-threshold (set below the on-threshold) |
| on_cycles | input | CW | On persistence in cycles, 0 selects the default |
| off_cycles | input | CW | Off persistence in cycles, 0 selects the default |
| det | output | 1 | Qualified presence in carrier mode |
| tone_lvl_ok | output | 1 | Qualified level in tone mode, for the tone detector |

## Verification
Two functions can fall in the same cycle: completion of the on-count and the clear caused by a mode change. The bench runs the carrier on-count to one cycle short of completion. It then toggles `mode` while keeping the level above both on-thresholds, so the timer would have expired at that exact edge. The clear must win, with both outputs low afterwards. A full new on-count under the new mode must then pass before `tone_lvl_ok` rises, and not one cycle earlier.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic {
        SPD_CARRIER = 1'b0,
        SPD_TONE    = 1'b1
    } spd_mode_e;

endpackage

// File: rtl/spd_thr_sel.sv
module spd_thr_sel
    import spd_pkg::*;
#(
    parameter int LW = 12
) (
    input  spd_mode_e       mode_i,
    input  logic [LW-1:0]   car_on_i,
    input  logic [LW-1:0]   car_off_i,
    input  logic [LW-1:0]   tone_on_i,
    input  logic [LW-1:0]   tone_off_i,
    output logic [LW-1:0]   on_thr_o,
    output logic [LW-1:0]   off_thr_o
);

    // The threshold pair follows the live mode input, so the first edge
    // after a mode switch already compares against the new pair.
    always_comb begin
        if (mode_i == SPD_TONE) begin
            on_thr_o  = tone_on_i;
            off_thr_o = tone_off_i;
        end else begin
            on_thr_o  = car_on_i;
            off_thr_o = car_off_i;
        end
    end

endmodule

// File: rtl/spd_compare.sv
module spd_compare #(
    parameter int LW = 12
) (
    input  logic [LW-1:0] level_i,
    input  logic [LW-1:0] on_thr_i,
    input  logic [LW-1:0] off_thr_i,
    output logic          above_on_o,
    output logic          below_off_o
);

    // Strict comparisons on both sides: a level equal to either
    // threshold sits inside the hysteresis band.
    always_comb begin
        above_on_o  = (level_i > on_thr_i);
        below_off_o = (level_i < off_thr_i);
    end

endmodule

// File: rtl/spd_persist.sv
module spd_persist
    import spd_pkg::*;
#(
    parameter int CW          = 20,
    parameter int DEF_ON_CYC  = 1_000_000,
    parameter int DEF_OFF_CYC = 400_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  spd_mode_e     mode_i,
    input  logic          above_on_i,
    input  logic          below_off_i,
    input  logic [CW-1:0] on_cycles_i,
    input  logic [CW-1:0] off_cycles_i,
    output logic          det_o,
    output logic          tone_o
);

    localparam logic [CW-1:0] DEF_ON  = CW'(DEF_ON_CYC);
    localparam logic [CW-1:0] DEF_OFF = CW'(DEF_OFF_CYC);
    localparam logic [CW-1:0] ONE     = CW'(1);

    typedef struct packed {
        spd_mode_e     mode;
        logic          det;
        logic          tone;
        logic [CW-1:0] on_cnt;
        logic [CW-1:0] off_cnt;
    } st_t;

    st_t st_d, st_q;

    logic [CW-1:0] on_lim, off_lim;
    logic          flag_q, flag_n, mode_chg;
    logic          on_done, off_done;

    always_comb begin
        on_lim   = (on_cycles_i  == '0) ? DEF_ON  : on_cycles_i;
        off_lim  = (off_cycles_i == '0) ? DEF_OFF : off_cycles_i;
        flag_q   = st_q.det | st_q.tone;
        mode_chg = (mode_i != st_q.mode);
        on_done  = (st_q.on_cnt  >= on_lim  - ONE);
        off_done = (st_q.off_cnt >= off_lim - ONE);
    end

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_i;
        flag_n    = flag_q;
        if (mode_chg) begin
            flag_n       = 1'b0;
            st_d.on_cnt  = '0;
            st_d.off_cnt = '0;
        end else if (!flag_q) begin
            st_d.off_cnt = '0;
            if (above_on_i) begin
                if (on_done) begin
                    flag_n      = 1'b1;
                    st_d.on_cnt = '0;
                end else begin
                    st_d.on_cnt = st_q.on_cnt + ONE;
                end
            end else begin
                st_d.on_cnt = '0;
            end
        end else begin
            st_d.on_cnt = '0;
            if (below_off_i) begin
                if (off_done) begin
                    flag_n       = 1'b0;
                    st_d.off_cnt = '0;
                end else begin
                    st_d.off_cnt = st_q.off_cnt + ONE;
                end
            end else begin
                st_d.off_cnt = '0;
            end
        end
        st_d.det  = flag_n & (mode_i == SPD_CARRIER);
        st_d.tone = flag_n & (mode_i == SPD_TONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: SPD_CARRIER, det: 1'b0, tone: 1'b0,
                      on_cnt: '0, off_cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign det_o  = st_q.det;
    assign tone_o = st_q.tone;

    // R2: the flag can only rise after an edge at which the level was above
    a_r2_rise_needs_above: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(above_on_i));

    // R4, R8: the flag only falls on a below-off sample or a mode change
    a_r4_fall_needs_below: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> ($past(below_off_i) || $past(mode_chg)));

    // R3: a not-above sample while clear leaves the on-timer at zero
    a_r3_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !above_on_i) |=> (st_q.on_cnt == '0));

    // R5: a not-below sample while set leaves the off-timer at zero
    a_r5_off_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !below_off_i && !mode_chg) |=> (st_q.off_cnt == '0 && flag_q));

    // R8: a mode change clears the flag and both timers
    a_r8_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (!flag_q && st_q.on_cnt == '0 && st_q.off_cnt == '0));

endmodule

// File: rtl/sig_presence_det.sv
module sig_presence_det
    import spd_pkg::*;
#(
    parameter int LW          = 12,
    parameter int CW          = 20,
    parameter int DEF_ON_CYC  = 1_000_000,
    parameter int DEF_OFF_CYC = 400_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] car_on_thr,
    input  logic [LW-1:0] car_off_thr,
    input  logic [LW-1:0] tone_on_thr,
    input  logic [LW-1:0] tone_off_thr,
    input  logic [CW-1:0] on_cycles,
    input  logic [CW-1:0] off_cycles,
    output logic          det,
    output logic          tone_lvl_ok
);

    spd_mode_e     mode_e;
    logic [LW-1:0] on_thr, off_thr;
    logic          above_on, below_off;

    assign mode_e = spd_mode_e'(mode);

    spd_thr_sel #(.LW(LW)) thr_i (
        .mode_i     (mode_e),
        .car_on_i   (car_on_thr),
        .car_off_i  (car_off_thr),
        .tone_on_i  (tone_on_thr),
        .tone_off_i (tone_off_thr),
        .on_thr_o   (on_thr),
        .off_thr_o  (off_thr)
    );

    spd_compare #(.LW(LW)) cmp_i (
        .level_i     (level),
        .on_thr_i    (on_thr),
        .off_thr_i   (off_thr),
        .above_on_o  (above_on),
        .below_off_o (below_off)
    );

    spd_persist #(
        .CW          (CW),
        .DEF_ON_CYC  (DEF_ON_CYC),
        .DEF_OFF_CYC (DEF_OFF_CYC)
    ) per_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_e),
        .above_on_i   (above_on),
        .below_off_i  (below_off),
        .on_cycles_i  (on_cycles),
        .off_cycles_i (off_cycles),
        .det_o        (det),
        .tone_o       (tone_lvl_ok)
    );

    // R10: the two qualified outputs are mutually exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(det && tone_lvl_ok));

    // R7: in tone mode det is low one edge after the mode is seen
    a_r7_det_low_in_tone: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 1'b1) |=> !det);

endmodule

// File: tb/sig_presence_det_tb.sv
module sig_presence_det_tb_top;

    localparam int LW = 12;
    localparam int CW = 8;
    localparam int DON = 40;
    localparam int DOFF = 16;
    localparam int NON = 5;
    localparam int NOFF = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic [LW-1:0] level = '0;
    logic [LW-1:0] car_on_thr = 12'd800;
    logic [LW-1:0] car_off_thr = 12'd600;
    logic [LW-1:0] tone_on_thr = 12'd1500;
    logic [LW-1:0] tone_off_thr = 12'd1200;
    logic [CW-1:0] on_cycles = CW'(NON);
    logic [CW-1:0] off_cycles = CW'(NOFF);
    logic          det, tone_lvl_ok;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sig_presence_det #(.LW(LW), .CW(CW), .DEF_ON_CYC(DON), .DEF_OFF_CYC(DOFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .level(level),
        .car_on_thr(car_on_thr), .car_off_thr(car_off_thr),
        .tone_on_thr(tone_on_thr), .tone_off_thr(tone_off_thr),
        .on_cycles(on_cycles), .off_cycles(off_cycles),
        .det(det), .tone_lvl_ok(tone_lvl_ok)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one sample; returns at the following negedge, after one posedge.
    task automatic cyc(input int lv, input int n);
        for (int i = 0; i < n; i++) begin
            level = LW'(lv);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 det in reset", det, 1'b0);
        chk("R1 tone in reset", tone_lvl_ok, 1'b0);
        rst_n = 1'b1;
        cyc(100, 1);
        chk("R1 det after reset", det, 1'b0);
        chk("R1 tone after reset", tone_lvl_ok, 1'b0);
    endtask

    task automatic t_rise();
        cyc(800, 20);
        chk("R2 equal level is not above", det, 1'b0);
        cyc(900, NON - 1);
        chk("R2 one short of on-count", det, 1'b0);
        cyc(900, 1);
        chk("R2 rise at on-count", det, 1'b1);
    endtask

    task automatic t_fall();
        cyc(500, NOFF - 1);
        chk("R4 one short of off-count", det, 1'b1);
        cyc(500, 1);
        chk("R4 fall at off-count", det, 1'b0);
    endtask

    task automatic t_on_restart();
        cyc(900, NON - 2);
        cyc(700, 1);
        cyc(900, NON - 1);
        chk("R3 restarted on-count not yet done", det, 1'b0);
        cyc(900, 1);
        chk("R3 rise after full restarted count", det, 1'b1);
        cyc(500, NOFF);
    endtask

    task automatic t_off_restart();
        cyc(900, NON);
        chk("R5 setup rise", det, 1'b1);
        cyc(500, NOFF - 1);
        cyc(600, 1);
        cyc(500, NOFF - 1);
        chk("R5 restarted off-count not yet done", det, 1'b1);
        cyc(500, 1);
        chk("R5 fall after full restarted count", det, 1'b0);
    endtask

    task automatic t_hyst();
        cyc(900, NON);
        cyc(700, 50);
        chk("R6 band holds set flag", det, 1'b1);
        cyc(500, NOFF);
        cyc(700, 50);
        chk("R6 band holds clear flag", det, 1'b0);
    endtask

    task automatic t_tone();
        mode = 1'b1;
        cyc(100, 1);
        cyc(1000, 20);
        chk("R7 carrier-level ignored in tone mode (tone)", tone_lvl_ok, 1'b0);
        chk("R7 carrier-level ignored in tone mode (det)", det, 1'b0);
        cyc(1600, NON - 1);
        chk("R7 tone one short", tone_lvl_ok, 1'b0);
        cyc(1600, 1);
        chk("R7 tone qualified", tone_lvl_ok, 1'b1);
        chk("R7 det held low", det, 1'b0);
        chk("R10 exclusive", det & tone_lvl_ok, 1'b0);
        cyc(1300, 30);
        chk("R6 tone band hold", tone_lvl_ok, 1'b1);
    endtask

    task automatic t_mode_clear();
        mode = 1'b0;
        cyc(1600, 1);
        chk("R8 tone cleared by mode change", tone_lvl_ok, 1'b0);
        chk("R8 det clear on change edge", det, 1'b0);
        cyc(1600, NON - 1);
        chk("R8 count restarts after change", det, 1'b0);
        cyc(1600, 1);
        chk("R8 det after fresh count", det, 1'b1);
        cyc(500, NOFF);
    endtask

    task automatic t_collide();
        cyc(900, NON - 1);
        chk("R8 collide setup", det, 1'b0);
        mode = 1'b1;
        cyc(1600, 1);
        chk("R8 mode change beats expiry (det)", det, 1'b0);
        chk("R8 mode change beats expiry (tone)", tone_lvl_ok, 1'b0);
        cyc(1600, NON - 1);
        chk("R8 tone not early after collide", tone_lvl_ok, 1'b0);
        cyc(1600, 1);
        chk("R8 tone after full count", tone_lvl_ok, 1'b1);
        mode = 1'b0;
        cyc(100, 2);
    endtask

    task automatic t_default();
        on_cycles = '0;
        off_cycles = '0;
        cyc(900, DON - 1);
        chk("R9 default on one short", det, 1'b0);
        cyc(900, 1);
        chk("R9 default on reached", det, 1'b1);
        cyc(500, DOFF - 1);
        chk("R9 default off one short", det, 1'b1);
        cyc(500, 1);
        chk("R9 default off reached", det, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_on_restart();
        t_off_restart();
        t_hyst();
        t_tone();
        t_mode_clear();
        t_collide();
        t_default();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule